// File: doc/BRIEF.md
# 8-bit Parallel Host Bus Master

This block drives an external 8-bit parallel peripheral bus on behalf of an internal requester. The requester holds a transfer request (address, write data, direction) with a valid flag. The block runs the bus sequence and then answers with a one-cycle ready pulse. For reads, the captured byte is on the read data output from that pulse on. The bus side has a chip select, an address latch strobe, separate read/output-enable and write strobes, a wide address output and a bidirectional 8-bit data path. The bidirectional path is split into out, in and output-enable.

A 2-bit mode field picks one of four bus sequences:
- Mode 0 multiplexes address and data on the 8 data pins.
- Mode 1 keeps the address on its own pins.
- Mode 2 streams reads by switching the address while the output enable stays asserted.
- Mode 3 talks to an external FIFO. It drives no address and is paced by full and empty flags.

Each direction has its own data phase width, set in steps of two clocks, plus a one-clock trim bit. All configuration is captured when a transfer starts.

Top module: `hb8_master`

## Requirements
- R1: While reset is asserted and after its release with no request, bus_cs_o, bus_ale_o, bus_rd_o, bus_wr_o and req_ready_o are low and req_rdata_o is zero.
- R2: In a write, bus_wr_o stays high for 2*(W+1) consecutive clocks, where W is the 2-bit write wait-state code (0..3 gives 2, 4, 6 or 8).
- R3: In a read, bus_rd_o stays high for 2*(R+1) consecutive clocks, where R is the 2-bit read wait-state code.
- R4: A set write trim bit (or read trim bit) shortens the matching strobe by exactly one clock, so odd widths 1, 3, 5 and 7 are reachable.
- R5: Mode 0 (code 0) adds one address clock before the data phase. In that clock bus_ale_o is high, bus_ad_oe_o is high and bus_ad_o carries address bits [7:0]. The strobe begins in the very next clock, and the address clock does not change with the wait-state codes.
- R6: Modes 0 to 2 drive the request address on bus_addr_o whenever bus_cs_o is high. Mode 1 (code 1) has no address clock. During a write strobe, bus_ad_oe_o is high and bus_ad_o carries the write data.
- R7: In mode 2 (code 2), after a read completes, bus_rd_o and bus_cs_o stay high for the ready clock and the following clock. If a mode 2 read request is present in that following clock, the next data phase starts with no gap in bus_rd_o. Otherwise bus_rd_o falls.
- R8: In mode 3 (code 3), bus_ale_o stays low and bus_addr_o is zero. A write does not start while fifo_full_i is high, and a read does not start while fifo_empty_i is high. req_ready_o stays low while the request waits.
- R9: Read data is captured from bus_ad_i at the clock edge that ends the last strobe clock. req_ready_o is high for exactly the one clock after the data phase, and req_rdata_o changes at no other edge.
- R10: Mode, direction, wait-state codes and trim bits are taken at the clock a transfer is accepted. Changes during the transfer do not alter its strobe widths or sequence.
- R11: bus_rd_o and bus_wr_o are never high together, and any of bus_ale_o, bus_rd_o and bus_wr_o being high implies bus_cs_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2 | Bus sub-mode: 0 muxed, 1 separate, 2 streaming read, 3 FIFO |
| cfg_rd_ws_i | input | WS_W | Read wait-state code |
| cfg_wr_ws_i | input | WS_W | Write wait-state code |
| cfg_rd_trim_i | input | 1 | Shorten read strobe by one clock |
| cfg_wr_trim_i | input | 1 | Shorten write strobe by one clock |
| req_valid_i | input | 1 | Request present, held until ready |
| req_we_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| req_ready_o | output | 1 | One-clock completion pulse |
| req_rdata_o | output | DW | Last captured read byte |
| bus_cs_o | output | 1 | Chip select, active high |
| bus_ale_o | output | 1 | Address latch strobe |
| bus_rd_o | output | 1 | Read / output enable strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_addr_o | output | AW | Separate address pins |
| bus_ad_o | output | DW | Data pins, driven value |
| bus_ad_oe_o | output | 1 | Data pin output enable |
| bus_ad_i | input | DW | Data pins, sampled value |
| fifo_full_i | input | 1 | External FIFO full |
| fifo_empty_i | input | 1 | External FIFO empty |

## Verification
Two events can fall in the same clock: a configuration change and the acceptance of a transfer. A FIFO flag can also change in the clock a gated request is waiting. The bench changes the mode and wait-state codes a few clocks into a long write and also flips them at the edge where the next request is taken. It then judges the strobe width against the value that was in force at acceptance. It also releases fifo_full_i and fifo_empty_i while a request is held, and compares every clock against a reference model that builds the whole expected waveform of a transfer at its acceptance edge. Read data on bus_ad_i changes every clock, so capture one clock early or late shows up as a wrong byte.

// File: rtl/hb8_pkg.sv
`timescale 1ns/1ps
package hb8_pkg;
  typedef enum logic [1:0] {
    MD_MUX   = 2'd0,
    MD_SPLIT = 2'd1,
    MD_CONT  = 2'd2,
    MD_FIFO  = 2'd3
  } hb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } hb_state_e;
endpackage

// File: rtl/hb8_phase_timer.sv
`timescale 1ns/1ps
module hb8_phase_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/hb8_seq.sv
`timescale 1ns/1ps
module hb8_seq
  import hb8_pkg::*;
#(
  parameter int unsigned WS_W = 2,
  localparam int unsigned CW  = WS_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      cfg_mode_i,
  input  logic [WS_W-1:0] cfg_rd_ws_i,
  input  logic [WS_W-1:0] cfg_wr_ws_i,
  input  logic            cfg_rd_trim_i,
  input  logic            cfg_wr_trim_i,
  input  logic            req_valid_i,
  input  logic            req_we_i,
  input  logic            fifo_full_i,
  input  logic            fifo_empty_i,
  input  logic            last_i,
  output hb_state_e       st_o,
  output hb_mode_e        mode_o,
  output logic            we_o,
  output logic            accept_o,
  output logic            hold_o,
  output logic            sample_o,
  output logic            load_o,
  output logic [CW-1:0]   load_val_o
);
  hb_state_e       st_q, st_d;
  hb_mode_e        mode_q, mode_in;
  logic            we_q, cont_q;
  logic [WS_W-1:0] rws_q, wws_q;
  logic            rtr_q, wtr_q;
  logic            blocked, cont_hit, accept;

  // strobe clocks minus one: 2*ws + 1 - trim
  function automatic logic [CW-1:0] last_idx(input logic [WS_W-1:0] ws, input logic trim);
    return {ws, 1'b1} - CW'(trim);
  endfunction

  assign mode_in  = hb_mode_e'(cfg_mode_i);
  assign blocked  = (mode_in == MD_FIFO) && (req_we_i ? fifo_full_i : fifo_empty_i);
  assign cont_hit = cont_q && req_valid_i && !req_we_i && (mode_in == MD_CONT);
  assign accept   = (st_q == ST_IDLE) && (cont_q ? cont_hit : (req_valid_i && !blocked));

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    case (st_q)
      ST_IDLE: if (accept) begin
        if (mode_in == MD_MUX) st_d = ST_ADDR;
        else begin
          st_d       = ST_DATA;
          load_o     = 1'b1;
          load_val_o = req_we_i ? last_idx(cfg_wr_ws_i, cfg_wr_trim_i)
                                : last_idx(cfg_rd_ws_i, cfg_rd_trim_i);
        end
      end
      ST_ADDR: begin
        st_d       = ST_DATA;
        load_o     = 1'b1;
        load_val_o = we_q ? last_idx(wws_q, wtr_q) : last_idx(rws_q, rtr_q);
      end
      ST_DATA: if (last_i) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= MD_MUX;
      we_q   <= 1'b0;
      cont_q <= 1'b0;
      rws_q  <= '0;
      wws_q  <= '0;
      rtr_q  <= 1'b0;
      wtr_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        mode_q <= mode_in;
        we_q   <= req_we_i;
        rws_q  <= cfg_rd_ws_i;
        wws_q  <= cfg_wr_ws_i;
        rtr_q  <= cfg_rd_trim_i;
        wtr_q  <= cfg_wr_trim_i;
      end
      if (st_q == ST_DONE)      cont_q <= (mode_q == MD_CONT) && !we_q;
      else if (st_q == ST_IDLE) cont_q <= 1'b0;
    end
  end

  assign st_o     = st_q;
  assign mode_o   = mode_q;
  assign we_o     = we_q;
  assign accept_o = accept;
  assign hold_o   = ((st_q == ST_IDLE) && cont_q) ||
                    ((st_q == ST_DONE) && (mode_q == MD_CONT) && !we_q);
  assign sample_o = (st_q == ST_DATA) && last_i && !we_q;
endmodule

// File: rtl/hb8_datapath.sv
`timescale 1ns/1ps
module hb8_datapath
  import hb8_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          sample_i,
  input  logic          hold_i,
  input  hb_state_e     st_i,
  input  hb_mode_e      mode_i,
  input  logic          we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] bus_ad_i,
  output logic [DW-1:0] req_rdata_o,
  output logic          req_ready_o,
  output logic          bus_cs_o,
  output logic          bus_ale_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (sample_i) rdata_q <= bus_ad_i;
    end
  end

  assign bus_cs_o    = (st_i == ST_ADDR) || (st_i == ST_DATA) || hold_i;
  assign bus_ale_o   = (st_i == ST_ADDR);
  assign bus_rd_o    = ((st_i == ST_DATA) && !we_i) || hold_i;
  assign bus_wr_o    = (st_i == ST_DATA) && we_i;
  assign bus_ad_oe_o = (st_i == ST_ADDR) || ((st_i == ST_DATA) && we_i);
  assign bus_ad_o    = (st_i == ST_ADDR) ? addr_q[DW-1:0] : wdata_q;
  assign bus_addr_o  = (mode_i == MD_FIFO) ? '0 : addr_q;
  assign req_ready_o = (st_i == ST_DONE);
  assign req_rdata_o = rdata_q;
endmodule

// File: rtl/hb8_master.sv
`timescale 1ns/1ps
module hb8_master
  import hb8_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 8,
  parameter int unsigned WS_W = 2,
  localparam int unsigned CW  = WS_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      cfg_mode_i,
  input  logic [WS_W-1:0] cfg_rd_ws_i,
  input  logic [WS_W-1:0] cfg_wr_ws_i,
  input  logic            cfg_rd_trim_i,
  input  logic            cfg_wr_trim_i,
  input  logic            req_valid_i,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            req_ready_o,
  output logic [DW-1:0]   req_rdata_o,
  output logic            bus_cs_o,
  output logic            bus_ale_o,
  output logic            bus_rd_o,
  output logic            bus_wr_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_ad_o,
  output logic            bus_ad_oe_o,
  input  logic [DW-1:0]   bus_ad_i,
  input  logic            fifo_full_i,
  input  logic            fifo_empty_i
);
  hb_state_e     st;
  hb_mode_e      mode_q;
  logic          we_q, accept, hold, sample, load, last;
  logic [CW-1:0] load_val;

  hb8_seq #(.WS_W(WS_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_mode_i   (cfg_mode_i),
    .cfg_rd_ws_i  (cfg_rd_ws_i),
    .cfg_wr_ws_i  (cfg_wr_ws_i),
    .cfg_rd_trim_i(cfg_rd_trim_i),
    .cfg_wr_trim_i(cfg_wr_trim_i),
    .req_valid_i  (req_valid_i),
    .req_we_i     (req_we_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .last_i       (last),
    .st_o         (st),
    .mode_o       (mode_q),
    .we_o         (we_q),
    .accept_o     (accept),
    .hold_o       (hold),
    .sample_o     (sample),
    .load_o       (load),
    .load_val_o   (load_val)
  );

  hb8_phase_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .last_o    (last)
  );

  hb8_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .sample_i    (sample),
    .hold_i      (hold),
    .st_i        (st),
    .mode_i      (mode_q),
    .we_i        (we_q),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .bus_ad_i    (bus_ad_i),
    .req_rdata_o (req_rdata_o),
    .req_ready_o (req_ready_o),
    .bus_cs_o    (bus_cs_o),
    .bus_ale_o   (bus_ale_o),
    .bus_rd_o    (bus_rd_o),
    .bus_wr_o    (bus_wr_o),
    .bus_addr_o  (bus_addr_o),
    .bus_ad_o    (bus_ad_o),
    .bus_ad_oe_o (bus_ad_oe_o)
  );
endmodule

// File: rtl/hb8_master_chk.sv
`timescale 1ns/1ps
module hb8_master_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    cfg_mode_i,
  input logic          req_valid_i,
  input logic          req_we_i,
  input logic          fifo_full_i,
  input logic          req_ready_o,
  input logic [DW-1:0] req_rdata_o,
  input logic          bus_cs_o,
  input logic          bus_ale_o,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic [1:0]    mode_q
);
  assert_ale_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> !bus_ale_o);

  assert_ale_to_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> (bus_rd_o || bus_wr_o));

  assert_fifo_no_ale_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd3 && bus_cs_o) |-> !bus_ale_o);

  assert_fifo_full_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == 2'd3 && req_valid_i && req_we_i && fifo_full_i && !bus_cs_o) |=> !bus_wr_o);

  assert_ready_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_o |=> $stable(req_rdata_o));

  assert_rd_wr_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  assert_strobe_in_cs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o || bus_ale_o) |-> bus_cs_o);
endmodule

bind hb8_master hb8_master_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_mode_i  (cfg_mode_i),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .fifo_full_i (fifo_full_i),
  .req_ready_o (req_ready_o),
  .req_rdata_o (req_rdata_o),
  .bus_cs_o    (bus_cs_o),
  .bus_ale_o   (bus_ale_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wr_o    (bus_wr_o),
  .mode_q      (mode_q)
);

// File: tb/hb8_master_bench.sv
`timescale 1ns/1ps
module hb8_master_bench;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [1:0]    cfg_mode = 2'd1, rws = 2'd0, wws = 2'd0;
  logic          rtr = 1'b0, wtr = 1'b0;
  logic          valid = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, ad_in = '0;
  logic          full = 1'b0, empty = 1'b0;

  logic          ready, cs, ale, rd, wr, ad_oe;
  logic [DW-1:0] rdata, ad_out;
  logic [AW-1:0] addr_out;

  hb8_master u_hb8_master (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg_mode), .cfg_rd_ws_i(rws), .cfg_wr_ws_i(wws),
    .cfg_rd_trim_i(rtr), .cfg_wr_trim_i(wtr), .req_valid_i(valid), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(ready), .req_rdata_o(rdata),
    .bus_cs_o(cs), .bus_ale_o(ale), .bus_rd_o(rd), .bus_wr_o(wr), .bus_addr_o(addr_out),
    .bus_ad_o(ad_out), .bus_ad_oe_o(ad_oe), .bus_ad_i(ad_in),
    .fifo_full_i(full), .fifo_empty_i(empty)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // expected waveform, one entry per clock
  typedef struct {
    bit idle, done, cont, smp;
    bit cs, ale, rd, wr, oe, rdy;
    logic [DW-1:0] ad;
    logic [AW-1:0] addr;
  } frame_t;

  frame_t        exp_q[$];
  frame_t        cur;
  bit            m_cont;
  logic [DW-1:0] m_rdata;
  logic [AW-1:0] m_addr;
  bit            run_chk = 1'b0;

  function automatic frame_t blank();
    frame_t f;
    f.idle = 0; f.done = 0; f.cont = 0; f.smp = 0;
    f.cs = 0; f.ale = 0; f.rd = 0; f.wr = 0; f.oe = 0; f.rdy = 0;
    f.ad = '0; f.addr = m_addr;
    return f;
  endfunction

  function automatic frame_t idle_f(input bit c);
    frame_t f = blank();
    f.idle = 1; f.cs = c; f.rd = c;
    return f;
  endfunction

  task automatic build(input bit w, input int md, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int ws, input bit tr);
    int n = 2 * (ws + 1) - int'(tr);
    frame_t f;
    m_addr = (md == 3) ? '0 : a;
    if (md == 0) begin
      f = blank(); f.cs = 1; f.ale = 1; f.oe = 1; f.ad = a[DW-1:0];
      exp_q.push_back(f);
    end
    for (int i = 0; i < n; i++) begin
      f = blank(); f.cs = 1; f.rd = !w; f.wr = w; f.oe = w; f.ad = d;
      f.smp = (i == n - 1) && !w;
      exp_q.push_back(f);
    end
    f = blank(); f.done = 1; f.rdy = 1; f.cont = (md == 2) && !w;
    f.cs = f.cont; f.rd = f.cont;
    exp_q.push_back(f);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      m_cont = 0; m_rdata = '0; m_addr = '0;
      cur = idle_f(0);
    end else begin
      bit was;
      if (cur.smp) m_rdata = ad_in;
      if (cur.done) m_cont = cur.cont;
      if (cur.idle) begin
        was = m_cont;
        m_cont = 0;
        if (was) begin
          if (valid && !we && cfg_mode == 2'd2) build(0, 2, addr, wdata, int'(rws), rtr);
        end else if (valid && !(cfg_mode == 2'd3 && (we ? full : empty))) begin
          build(we, int'(cfg_mode), addr, wdata, we ? int'(wws) : int'(rws), we ? wtr : rtr);
        end
      end
      if (exp_q.size() != 0) cur = exp_q.pop_front();
      else cur = idle_f(m_cont);
    end
  end

  // read-back data on the pins changes every clock
  always @(negedge clk) ad_in <= ad_in + 8'h13;

  int wr_run = 0, rd_run = 0, last_wr_len = 0, last_rd_len = 0, rd_falls = 0;

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      check(cs == cur.cs, "R11", "cs", cs, cur.cs);
      check(ale == cur.ale, "R5", "ale", ale, cur.ale);
      check(wr == cur.wr, "R2", "wr", wr, cur.wr);
      check(rd == cur.rd, "R3", "rd", rd, cur.rd);
      check(ad_oe == cur.oe, "R6", "ad_oe", ad_oe, cur.oe);
      if (cur.oe) check(ad_out == cur.ad, "R6", "ad_out", ad_out, cur.ad);
      if (cur.cs) check(addr_out == cur.addr, "R6", "addr_out", addr_out, cur.addr);
      check(ready == cur.rdy, "R9", "ready", ready, cur.rdy);
      check(rdata == m_rdata, "R9", "rdata", rdata, m_rdata);
    end
    if (wr) wr_run++;
    else if (wr_run != 0) begin last_wr_len = wr_run; wr_run = 0; end
    if (rd) rd_run++;
    else if (rd_run != 0) begin last_rd_len = rd_run; rd_run = 0; rd_falls++; end
  end

  task automatic txn(input bit w, input int md, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int rw, input int ww, input bit rt, input bit wt);
    cfg_mode = 2'(md); rws = 2'(rw); wws = 2'(ww); rtr = rt; wtr = wt;
    we = w; addr = a; wdata = d; valid = 1'b1;
    do @(negedge clk); while (!ready);
    valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!cs && !ale && !rd && !wr && !ready, "R1", "strobes in reset", {cs, ale, rd, wr, ready}, 0);
    check(rdata == '0, "R1", "rdata in reset", rdata, 0);
    rst_n = 1'b1;
    run_chk = 1'b1;
    repeat (2) @(negedge clk);
    check(!cs && !rd && !wr && !ready, "R1", "idle after reset", {cs, rd, wr, ready}, 0);

    // R2: write widths, separate-address mode
    for (int ws = 0; ws < 4; ws++) begin
      txn(1, 1, 16'h1200 + 16'(ws), 8'hA0 + 8'(ws), 0, ws, 0, 0);
      @(negedge clk);
      check(last_wr_len == 2 * (ws + 1), "R2", "wr width", last_wr_len, 2 * (ws + 1));
    end
    // R3: read widths
    for (int ws = 0; ws < 4; ws++) begin
      txn(0, 1, 16'h3400 + 16'(ws), 8'h00, ws, 0, 0, 0);
      @(negedge clk);
      check(last_rd_len == 2 * (ws + 1), "R3", "rd width", last_rd_len, 2 * (ws + 1));
    end
    // R4: trims
    txn(1, 1, 16'h0042, 8'h5A, 0, 1, 0, 1);
    @(negedge clk);
    check(last_wr_len == 3, "R4", "trimmed wr width", last_wr_len, 3);
    txn(0, 1, 16'h0043, 8'h00, 0, 0, 1, 0);
    @(negedge clk);
    check(last_rd_len == 1, "R4", "trimmed rd width", last_rd_len, 1);

    // R5: muxed mode write and read
    txn(1, 0, 16'hBEEF, 8'h77, 0, 2, 0, 0);
    @(negedge clk);
    check(last_wr_len == 6, "R5", "muxed wr width", last_wr_len, 6);
    txn(0, 0, 16'hCAFE, 8'h00, 1, 0, 0, 1);
    @(negedge clk);

    // R7: streaming reads, rd must not drop between them
    f0 = rd_falls;
    txn(0, 2, 16'h0100, 8'h00, 0, 0, 0, 0);
    txn(0, 2, 16'h0101, 8'h00, 1, 0, 0, 0);
    txn(0, 2, 16'h0102, 8'h00, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(rd_falls - f0 == 1, "R7", "rd falls over stream", rd_falls - f0, 1);
    // streaming read followed by a write: rd drops first
    txn(0, 2, 16'h0200, 8'h00, 0, 0, 0, 0);
    txn(1, 2, 16'h0201, 8'h3C, 0, 0, 0, 0);
    @(negedge clk);

    // R8: FIFO mode waits on full / empty
    full = 1'b1;
    fork
      txn(1, 3, 16'hFFFF, 8'h99, 0, 1, 0, 0);
      begin
        repeat (5) @(negedge clk);
        check(!ready && !wr, "R8", "write held while full", {ready, wr}, 0);
        full = 1'b0;
      end
    join
    empty = 1'b1;
    fork
      txn(0, 3, 16'hFFFF, 8'h00, 1, 0, 0, 0);
      begin
        repeat (4) @(negedge clk);
        check(!ready && !rd, "R8", "read held while empty", {ready, rd}, 0);
        empty = 1'b0;
      end
    join
    @(negedge clk);

    // R10: config changes during a transfer and at acceptance
    fork
      txn(1, 1, 16'h0A0A, 8'h11, 0, 3, 0, 0);
      begin
        repeat (3) @(negedge clk);
        wws = 2'd0; wtr = 1'b1; cfg_mode = 2'd0;
      end
    join
    @(negedge clk);
    check(last_wr_len == 8, "R10", "wr width after cfg change", last_wr_len, 8);
    txn(0, 1, 16'h0B0B, 8'h00, 2, 0, 0, 0);
    cfg_mode = 2'd3; rws = 2'd0; rtr = 1'b1; empty = 1'b1;
    @(negedge clk);
    check(last_rd_len == 6, "R10", "rd width vs accept cfg", last_rd_len, 6);
    empty = 1'b0;

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule